// File: doc/BRIEF.md
# Masked Block-Write Row Engine

This block holds one memory row of 512 columns, each 16 bits wide, and fills groups of four neighbouring columns with a stored colour word in a single clock cycle. The data word is split into four 4-bit quadrants. Each quadrant has its own 4-bit column-enable nibble, so every quadrant can pick a different subset of the four columns. A per-bit write mask and two byte enables further restrict which bits change. The block is used to clear or fill rectangles of pixel storage quickly while leaving masked planes and masked pixels untouched.

An operation code selects the cycle's action. The shared `din` bus carries write data, a colour value, a write-mask value or the column-enable word, depending on the operation. Ordinary single-column writes and reads are also supported. A read returns its word one cycle after it is issued.

Top module: `bwr_row_engine`

## Requirements
- R1: Operation codes on `op`: 0 idle, 1 read, 2 single write, 3 block write, 4 load colour from `din`, 5 load write mask from `din`. A block write at column address A updates columns 4*(A>>2) to 4*(A>>2)+3, and address bits 1:0 have no effect on it.
- R2: In a block write, `din` holds the column-enable word. Bit 4q+c enables column c (0..3) of the selected group in quadrant q, where quadrant q is data bits 4q..4q+3. A 0 leaves those four bits of that column unchanged.
- R3: In a block write, a data bit i is changed only where write-mask bit i is 1. Where the write-mask bit is 0, the bit keeps its old value.
- R4: The value a block write places in bit i is bit i of the colour register, as loaded by the most recent op 4 or reset. The colour register changes only on op 4 or reset.
- R5: `be[0]` gates data bits 7:0 and `be[1]` gates bits 15:8. This applies to both single and block writes, and a 0 keeps the old bits.
- R6: A single write updates only the addressed column with `din`, under the byte enables only. It does not apply the write mask.
- R7: A read (op 1) presents the addressed column's stored word on `rdata` after the next rising clock edge. Writes take effect at the edge that accepts them.
- R8: Synchronous active-low reset sets the colour register to zero and the write mask to all ones. Row contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Operation code (R1) |
| addr | input | 9 | Column address |
| din | input | 16 | Write data, colour, write mask or column-enable word |
| be | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte |
| rdata | output | 16 | Read data, one cycle after a read |

## Verification
The hardest situation to reach is a block write in which all three masks disagree. A column is enabled in one quadrant and disabled in another, the write mask clears some bits, and one byte enable is off while the column word would enable that byte. Rows start unknown, so the stimulus first fills groups with known all-zero and all-one words. It then loads a colour and a write mask whose nibbles differ. The column-enable words are chosen so that each quadrant selects a different column subset, and one word enables columns that a low byte enable must still block. Read-back of every column of the group then separates each gate from the others.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_READ  = 3'd1,
      OP_WRITE = 3'd2,
      OP_BLOCK = 3'd3,
      OP_LDCOL = 3'd4,
      OP_LDWM  = 3'd5
   } op_e;
endpackage

// File: rtl/bwr_mask_gen.sv
// Per-column write enable, bit mask and data for one cycle.
module bwr_mask_gen
   import bwr_pkg::*;
#(
   parameter int DW = 16,
   parameter int QW = 4,
   localparam int NQ = DW / QW,
   localparam int BC = DW / NQ,
   localparam int SW = (BC > 1) ? $clog2(BC) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  op_e                    op,
   input  logic [SW-1:0]          col_sel,
   input  logic [DW-1:0]          din,
   input  logic [1:0]             be,
   input  logic [DW-1:0]          wmask,
   input  logic [DW-1:0]          colour,
   output logic [BC-1:0]          we,
   output logic [BC-1:0][DW-1:0]  bm,
   output logic [BC-1:0][DW-1:0]  wd
);
   localparam int HB = DW / 2;

   logic [DW-1:0] be_mask;
   logic          is_blk;
   logic          is_wr;

   assign is_blk = (op == OP_BLOCK);
   assign is_wr  = (op == OP_WRITE);

   for (genvar i = 0; i < DW; i++) begin : g_be
      if (i < HB) begin : g_lo
         assign be_mask[i] = be[0];
      end else begin : g_hi
         assign be_mask[i] = be[1];
      end
   end

   for (genvar c = 0; c < BC; c++) begin : g_col
      logic [DW-1:0] colm;
      for (genvar q = 0; q < NQ; q++) begin : g_q
         assign colm[q*QW +: QW] = {QW{din[q*BC + c]}};
      end
      assign we[c] = is_blk || (is_wr && (col_sel == SW'(c)));
      assign bm[c] = is_blk ? (be_mask & wmask & colm)
                   : is_wr  ? be_mask
                   : '0;
      assign wd[c] = is_blk ? colour : din;

      // R3: a block write never touches a bit the write mask protects
      a_r3_wmask_bound: assert property (@(posedge clk) disable iff (!rst_n)
         is_blk |-> ((bm[c] & ~wmask) == '0));
      // R5: a low byte enable blocks its byte in any write
      a_r5_byte_gate: assert property (@(posedge clk) disable iff (!rst_n)
         (!be[0] && we[c]) |-> (bm[c][HB-1:0] == '0));
   end

   // R6: a single write enables exactly one column
   a_r6_single_col: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> ($countones(we) == 1));
endmodule

// File: rtl/bwr_col_bank.sv
// Storage for one column position within every group of the row.
module bwr_col_bank #(
   parameter int DW    = 16,
   parameter int DEPTH = 128,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wd,
   input  logic [DW-1:0] bm,
   output logic [DW-1:0] rd
);
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we) begin
         mem[idx] <= (mem[idx] & ~bm) | (wd & bm);
      end
      if (re) begin
         rd_q <= mem[idx];
      end
   end

   assign rd = rd_q;
endmodule

// File: rtl/bwr_row_engine.sv
module bwr_row_engine
   import bwr_pkg::*;
#(
   parameter int NCOL = 512,
   parameter int DW   = 16,
   parameter int QW   = 4,
   localparam int AW  = $clog2(NCOL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    op,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic [1:0]    be,
   output logic [DW-1:0] rdata
);
   localparam int NQ    = DW / QW;
   localparam int BC    = DW / NQ;
   localparam int SW    = (BC > 1) ? $clog2(BC) : 1;
   localparam int NBLK  = NCOL / BC;
   localparam int BAW   = (NBLK > 1) ? $clog2(NBLK) : 1;

   initial begin
      assert (DW % QW == 0) else $error("data width must be a multiple of quadrant width");
      assert (DW % 2 == 0) else $error("data width must split into two bytes");
      assert (NQ * BC == DW) else $error("column-enable word must match data width");
      assert (NCOL % BC == 0) else $error("column count must be a multiple of group size");
      assert ((1 << AW) == NCOL) else $error("column count must be a power of two");
   end

   op_e           op_c;
   logic [DW-1:0] colour_q;
   logic [DW-1:0] wmask_q;
   logic [SW-1:0] rsel_q;
   logic [BC-1:0] we;
   logic [BC-1:0][DW-1:0] bm;
   logic [BC-1:0][DW-1:0] wd;
   logic [BC-1:0][DW-1:0] rd;
   logic [SW-1:0] col_sel;
   logic [BAW-1:0] blk;
   logic          re;

   assign op_c    = op_e'(op);
   assign col_sel = addr[SW-1:0];
   assign blk     = addr[AW-1:SW];
   assign re      = (op_c == OP_READ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         colour_q <= '0;
         wmask_q  <= '1;
      end else begin
         if (op_c == OP_LDCOL) colour_q <= din;
         if (op_c == OP_LDWM)  wmask_q  <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (re) rsel_q <= col_sel;
   end

   bwr_mask_gen #(.DW(DW), .QW(QW)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op_c),
      .col_sel(col_sel),
      .din    (din),
      .be     (be),
      .wmask  (wmask_q),
      .colour (colour_q),
      .we     (we),
      .bm     (bm),
      .wd     (wd)
   );

   for (genvar c = 0; c < BC; c++) begin : g_bank
      bwr_col_bank #(.DW(DW), .DEPTH(NBLK)) u_bank (
         .clk(clk),
         .we (we[c]),
         .re (re),
         .idx(blk),
         .wd (wd[c]),
         .bm (bm[c]),
         .rd (rd[c])
      );
   end

   assign rdata = rd[rsel_q];

   // R8: the cycle after reset the registers hold their reset values
   a_r8_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> ((colour_q == '0) && (wmask_q == '1)));
   // R4: the colour register moves only on its load operation
   a_r4_colour_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c != OP_LDCOL) |=> $stable(colour_q));
endmodule

// File: tb/bwr_row_engine_test.sv
`timescale 1ns/1ps
module bwr_row_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [8:0]  addr = '0;
   logic [15:0] din = '0;
   logic [1:0]  be = '0;
   logic [15:0] rdata;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bwr_row_engine uut (
      .clk(clk), .rst_n(rst_n), .op(op), .addr(addr),
      .din(din), .be(be), .rdata(rdata)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [8:0]  addr;
      logic [15:0] din;
      logic [1:0]  be;
      logic [15:0] exp;
      logic [3:0]  req;
      logic        chk;
   } vec_t;

   localparam int NV = 29;
   // op: 1 read, 2 write, 3 block write, 4 load colour, 5 load write mask
   localparam logic [50:0] TBL [NV] = '{
      {3'd2, 9'd0,   16'h0000, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd1,   16'h0000, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd2,   16'h0000, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd3,   16'h0000, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd4,   16'hFFFF, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd5,   16'hFFFF, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd6,   16'hFFFF, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd2, 9'd7,   16'hFFFF, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd1, 9'd2,   16'h0000, 2'b00, 16'h0000, 4'd7, 1'b1}, // R7 read latency
      {3'd1, 9'd5,   16'h0000, 2'b00, 16'hFFFF, 4'd6, 1'b1}, // R6 single write
      {3'd4, 9'd0,   16'h3CA5, 2'b00, 16'h0000, 4'd0, 1'b0}, // R4 colour load
      {3'd5, 9'd0,   16'hFF7E, 2'b00, 16'h0000, 4'd0, 1'b0}, // write mask load
      {3'd3, 9'd2,   16'h0F96, 2'b11, 16'h0000, 4'd0, 1'b0}, // R1 low bits ignored
      {3'd1, 9'd0,   16'h0000, 2'b00, 16'h0C20, 4'd2, 1'b1}, // R2
      {3'd1, 9'd1,   16'h0000, 2'b00, 16'h0C04, 4'd3, 1'b1}, // R3
      {3'd1, 9'd2,   16'h0000, 2'b00, 16'h0C04, 4'd4, 1'b1}, // R4
      {3'd1, 9'd3,   16'h0000, 2'b00, 16'h0C20, 4'd1, 1'b1}, // R1
      {3'd3, 9'd7,   16'hFFFF, 2'b01, 16'h0000, 4'd0, 1'b0},
      {3'd1, 9'd4,   16'h0000, 2'b00, 16'hFFA5, 4'd5, 1'b1}, // R5 upper kept
      {3'd1, 9'd7,   16'h0000, 2'b00, 16'hFFA5, 4'd1, 1'b1}, // R1 group 1
      {3'd3, 9'd4,   16'hA0FF, 2'b10, 16'h0000, 4'd0, 1'b0},
      {3'd1, 9'd4,   16'h0000, 2'b00, 16'hFFA5, 4'd5, 1'b1}, // R5 lower blocked
      {3'd1, 9'd5,   16'h0000, 2'b00, 16'h3FA5, 4'd2, 1'b1}, // R2 quadrant 3
      {3'd1, 9'd7,   16'h0000, 2'b00, 16'h3FA5, 4'd5, 1'b1}, // R5
      {3'd2, 9'd6,   16'h1234, 2'b01, 16'h0000, 4'd0, 1'b0},
      {3'd1, 9'd6,   16'h0000, 2'b00, 16'hFF34, 4'd6, 1'b1}, // R6 no write mask
      {3'd2, 9'd511, 16'hBEEF, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd3, 9'd511, 16'h0008, 2'b11, 16'h0000, 4'd0, 1'b0},
      {3'd1, 9'd511, 16'h0000, 2'b00, 16'hBEE5, 4'd3, 1'b1}  // R3 top group
   };

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d: rdata %h, expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [2:0] o, input logic [8:0] a,
                        input logic [15:0] d, input logic [1:0] b);
      op = o; addr = a; din = d; be = b;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: cycle %0d, expected end before 5000", cyc);
         finish_run();
      end
   end

   initial begin
      vec_t v;
      vec_t pend;
      bit   have;
      have = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         v = vec_t'(TBL[i]);
         @(negedge clk);
         if (have && pend.chk) check(int'(pend.req), rdata, pend.exp);
         drive(v.op, v.addr, v.din, v.be);
         pend = v;
         have = 1;
      end
      @(negedge clk);
      if (pend.chk) check(int'(pend.req), rdata, pend.exp);
      drive(3'd0, '0, '0, 2'b00);

      // R8: reset restores colour and write mask but keeps row contents
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive(3'd1, 9'd511, '0, 2'b00);
      @(negedge clk);
      check(8, rdata, 16'hBEE5);           // R8 row kept
      drive(3'd3, 9'd2, 16'hFFFF, 2'b11);  // colour 0, mask all ones
      @(negedge clk);
      drive(3'd1, 9'd1, '0, 2'b00);
      @(negedge clk);
      check(8, rdata, 16'h0000);           // R8 colour cleared
      drive(3'd1, 9'd3, '0, 2'b00);
      @(negedge clk);
      check(8, rdata, 16'h0000);           // R8 mask all ones
      drive(3'd0, '0, '0, 2'b00);

      // R4: a write-mask load leaves the colour register alone
      @(negedge clk);
      drive(3'd4, '0, 16'h00F0, 2'b00);
      @(negedge clk);
      drive(3'd5, '0, 16'hFFFF, 2'b00);
      @(negedge clk);
      drive(3'd3, 9'd4, 16'h2222, 2'b11);  // column 1 of group 1, all quadrants
      @(negedge clk);
      drive(3'd1, 9'd5, '0, 2'b00);
      @(negedge clk);
      check(4, rdata, 16'h00F0);           // R4 colour kept
      drive(3'd0, '0, '0, 2'b00);

      done = 1;
      @(negedge clk);
      finish_run();
   end
endmodule